// File: doc/BRIEF.md
# Cursor Coordinate Translator

This block turns the raw position word written for a hardware cursor into the pixel coordinates the overlay logic needs. The position word packs a horizontal and a vertical value. A small control byte carries a hot-spot offset. Each time a position write strobe arrives, the block computes the clamped X and Y coordinates and registers them. They appear on the outputs after that clock edge and stay there until the next strobe.

The vertical axis is inverted from a fixed top value. The horizontal axis is measured against an adaptive origin. That origin starts at a reset value and moves down permanently to the smallest raw X the block has seen. Software that uses a different base for horizontal values is therefore absorbed automatically. After the hot-spot nibbles are subtracted, each result is saturated to the range from 0 to the configured screen width or height. The display is normally 1280x1024.

Top module: `cur_coord_xlat`

## Requirements
- R1: After reset both outputs are 0 and the horizontal origin is 338, so the first write with raw X = 340 and hot-spot X = 0 yields X = 1.
- R2: Raw X is pos_word[31:16] and raw Y is pos_word[15:0], each read as a signed two's-complement 16-bit value.
- R3: A strobed position word of exactly zero drives both outputs to 0 and leaves the horizontal origin unchanged.
- R4: When a strobed, nonzero word carries a raw X below the current origin, the origin becomes that raw X. The origin never rises again until reset.
- R5: X is computed as (raw X − origin) / 2, truncated, minus ctrl_byte[7:4]. The origin used is the one already lowered by the same write.
- R6: Y is computed as 1146 − raw Y − ctrl_byte[3:0].
- R7: An X result greater than scr_w yields scr_w, and a Y result greater than scr_h yields scr_h. Both comparisons are signed.
- R8: A negative X or Y result yields 0.
- R9: The outputs change only at a clock edge where pos_wr is 1. They show the new value after that edge and hold it while pos_wr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pos_wr | input | 1 | Position write strobe; captures pos_word and ctrl_byte |
| pos_word | input | 32 | Raw position: X in [31:16], Y in [15:0], both signed |
| ctrl_byte | input | 8 | Hot-spot offset: X in [7:4], Y in [3:0] |
| scr_w | input | 13 | Screen width, the upper limit for X |
| scr_h | input | 13 | Screen height, the upper limit for Y |
| x_out | output | 13 | Clamped screen X |
| y_out | output | 13 | Clamped screen Y |

## Verification
The bench builds the block with its default parameters. These are 16-bit raw fields, 13-bit coordinates, origin reset 338 and top value 1146. With them, the raw values that typical software writes (for example −295 and 2265 horizontally) can be used directly. They also bring both limits within reach: 1280x1024 and a smaller 640x480 screen. The vectors lower the origin from 338 to a negative value and then show that later, larger X values do not raise it. They also show that a zero word leaves the origin alone, and they drive results past both the upper and the lower clamp. Directed tests cover hold without a strobe and the restoration of the origin by reset.

// File: rtl/cur_xlat_pkg.sv
package cur_xlat_pkg;
  parameter int RAW_W   = 16;
  parameter int CRD_W   = 13;
  parameter int NIB_W   = 4;
  parameter int WIDE_W  = RAW_W + 3;
  parameter int ORG_RST = 338;
  parameter int Y_TOP   = 1146;
  parameter int AXES    = 2;

  typedef logic signed [WIDE_W-1:0] wide_t;
  typedef logic [CRD_W-1:0]         crd_t;
endpackage

// File: rtl/cur_origin_trk.sv
module cur_origin_trk #(
  parameter int RAW_W   = 16,
  parameter int ORG_RST = 338
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_en,
  input  logic signed [RAW_W-1:0] raw_x,
  output logic signed [RAW_W-1:0] org_eff
);
  localparam logic signed [RAW_W-1:0] ORG_INIT = RAW_W'(ORG_RST);

  logic signed [RAW_W-1:0] org_q, org_d;

  // effective origin: already lowered by the write in progress
  always_comb begin
    org_eff = (raw_x < org_q) ? raw_x : org_q;
  end

  always_comb begin
    org_d = org_q;
    if (upd_en) org_d = org_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) org_q <= ORG_INIT;
    else        org_q <= org_d;
  end

  // R4
  org_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    org_q <= $past(org_q));

  // R4
  org_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (raw_x < org_q)) |=> (org_q == $past(raw_x)));
endmodule

// File: rtl/cur_axis_clamp.sv
module cur_axis_clamp #(
  parameter int WIDE_W = 19,
  parameter int CRD_W  = 13
) (
  input  logic signed [WIDE_W-1:0] val,
  input  logic [CRD_W-1:0]         lim,
  output logic [CRD_W-1:0]         res
);
  localparam int PAD = WIDE_W - CRD_W;

  logic signed [WIDE_W-1:0] lim_s;

  always_comb begin
    lim_s = $signed({{PAD{1'b0}}, lim});
    if (val > lim_s)         res = lim;
    else if (val < 0)        res = '0;
    else                     res = val[CRD_W-1:0];
  end
endmodule

// File: rtl/cur_coord_xlat.sv
module cur_coord_xlat
  import cur_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pos_wr,
  input  logic [31:0] pos_word,
  input  logic [7:0]  ctrl_byte,
  input  logic [12:0] scr_w,
  input  logic [12:0] scr_h,
  output logic [12:0] x_out,
  output logic [12:0] y_out
);
  localparam int HOT_W = 2 * NIB_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // field extraction
  logic signed [RAW_W-1:0] raw_x, raw_y, org_eff;
  logic [NIB_W-1:0]        hot_x, hot_y;
  logic                    word_zero, org_upd;

  assign raw_x     = $signed(pos_word[2*RAW_W-1:RAW_W]);
  assign raw_y     = $signed(pos_word[RAW_W-1:0]);
  assign hot_x     = ctrl_byte[HOT_W-1:NIB_W];
  assign hot_y     = ctrl_byte[NIB_W-1:0];
  assign word_zero = (pos_word == '0);
  assign org_upd   = pos_wr && !word_zero;

  cur_origin_trk #(.RAW_W(RAW_W), .ORG_RST(ORG_RST)) i_org (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .upd_en  (org_upd),
    .raw_x   (raw_x),
    .org_eff (org_eff)
  );

  // axis arithmetic
  wide_t dx, half_x;
  wide_t ax_val [AXES];
  crd_t  ax_lim [AXES];
  crd_t  ax_res [AXES];

  always_comb begin
    dx        = wide_t'(raw_x) - wide_t'(org_eff);  // never negative
    half_x    = dx >>> 1;                           // truncation for dx >= 0
    ax_val[0] = half_x - wide_t'({1'b0, hot_x});
    ax_val[1] = wide_t'(Y_TOP) - wide_t'(raw_y) - wide_t'({1'b0, hot_y});
    ax_lim[0] = scr_w;
    ax_lim[1] = scr_h;
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    cur_axis_clamp #(.WIDE_W(WIDE_W), .CRD_W(CRD_W)) i_clamp (
      .val (ax_val[a]),
      .lim (ax_lim[a]),
      .res (ax_res[a])
    );
  end

  // output registers
  crd_t x_q, y_q, x_d, y_d;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (pos_wr) begin
      x_d = word_zero ? '0 : ax_res[0];
      y_d = word_zero ? '0 : ax_res[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x_out = x_q;
  assign y_out = y_q;

  // R3
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pos_wr && pos_word == '0) |=> (x_out == '0 && y_out == '0));

  // R7
  x_limit_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    pos_wr |=> (x_out <= $past(scr_w)));

  // R7
  y_limit_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    pos_wr |=> (y_out <= $past(scr_h)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !pos_wr |=> ($stable(x_out) && $stable(y_out)));
endmodule

// File: tb/test_cur_coord_xlat.sv
module test_cur_coord_xlat;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pos_wr = 0;
  logic [31:0] pos_word = '0;
  logic [7:0]  ctrl_byte = '0;
  logic [12:0] scr_w = 13'd1280;
  logic [12:0] scr_h = 13'd1024;
  logic [12:0] x_out, y_out;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cur_coord_xlat i_cur_coord_xlat (
    .clk(clk), .rst_n(rst_n), .pos_wr(pos_wr), .pos_word(pos_word),
    .ctrl_byte(ctrl_byte), .scr_w(scr_w), .scr_h(scr_h),
    .x_out(x_out), .y_out(y_out)
  );

  // {pos_word, ctrl, width, height, exp_x, exp_y}
  localparam int NV = 13;
  localparam logic [91:0] VEC [NV] = '{
    {32'h021A_0092, 8'h00, 13'd1280, 13'd1024, 13'd100,  13'd1000}, // R5 R6 at origin 338
    {32'h03E8_0000, 8'h35, 13'd1280, 13'd1024, 13'd328,  13'd1024}, // R5 R7 hot-spot, y clamp
    {32'h0153_047A, 8'h00, 13'd1280, 13'd1024, 13'd0,    13'd0},    // R5 truncation
    {32'h0153_047A, 8'h11, 13'd1280, 13'd1024, 13'd0,    13'd0},    // R8 negative to 0
    {32'h0BB8_01F4, 8'h00, 13'd1280, 13'd1024, 13'd1280, 13'd646},  // R7 x clamp
    {32'hFED9_0064, 8'h00, 13'd1280, 13'd1024, 13'd0,    13'd1024}, // R2 R4 origin to -295
    {32'hFEDE_044C, 8'h20, 13'd1280, 13'd1024, 13'd0,    13'd46},   // R5 R6
    {32'hFEE7_0092, 8'h10, 13'd1280, 13'd1024, 13'd6,    13'd1000}, // R5
    {32'h021A_0092, 8'h00, 13'd1280, 13'd1024, 13'd416,  13'd1000}, // R4 origin stays low
    {32'h0000_0000, 8'h33, 13'd1280, 13'd1024, 13'd0,    13'd0},    // R3 zero word
    {32'hFEDB_047A, 8'h00, 13'd1280, 13'd1024, 13'd1,    13'd0},    // R3 origin unchanged
    {32'h07D0_0000, 8'h00, 13'd640,  13'd480,  13'd640,  13'd480},  // R7 small screen
    {32'hFED9_FFFF, 8'h00, 13'd640,  13'd480,  13'd0,    13'd480}   // R2 signed y
  };

  task automatic check(input string req, input logic [12:0] ex, input logic [12:0] ey);
    n_chk++;
    if (x_out !== ex || y_out !== ey) begin
      n_bad++;
      $display("FAIL %s: x=%0d y=%0d expected x=%0d y=%0d", req, x_out, y_out, ex, ey);
    end
  endtask

  task automatic write_pos(input logic [31:0] w, input logic [7:0] c,
                           input logic [12:0] sw, input logic [12:0] sh);
    @(negedge clk);
    pos_word = w; ctrl_byte = c; scr_w = sw; scr_h = sh; pos_wr = 1;
    @(negedge clk);
    pos_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset outputs", 13'd0, 13'd0);

    for (int i = 0; i < NV; i++) begin
      write_pos(VEC[i][91:60], VEC[i][59:52], VEC[i][51:39], VEC[i][38:26]);
      check($sformatf("R5 R6 R7 vector %0d", i), VEC[i][25:13], VEC[i][12:0]);
    end

    // R9: hold without strobe
    write_pos(32'h021A_0092, 8'h00, 13'd1280, 13'd1024);
    check("R9 strobed value", 13'd416, 13'd1000);
    @(negedge clk);
    pos_word = 32'h0BB8_0000; ctrl_byte = 8'hFF;
    repeat (3) @(negedge clk);
    check("R9 held without strobe", 13'd416, 13'd1000);

    // R1: reset restores origin 338
    do_reset();
    check("R1 outputs after second reset", 13'd0, 13'd0);
    write_pos(32'h0154_0092, 8'h00, 13'd1280, 13'd1024);
    check("R1 origin back to 338", 13'd1, 13'd1000);

    // R3: zero word right after reset keeps origin 338
    do_reset();
    write_pos(32'h0000_0000, 8'h00, 13'd1280, 13'd1024);
    check("R3 zero word after reset", 13'd0, 13'd0);
    write_pos(32'h0156_0092, 8'h00, 13'd1280, 13'd1024);
    check("R3 origin still 338", 13'd2, 13'd1000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule